// File: doc/BRIEF.md
# Keyed Set-to-Clear Control Register Block

This block is the register front end of a multi-channel timer controller. It keeps a 32-bit main control word, which drives the timer channels directly, and a second 32-bit control word that software reads and writes. A third register acts as a key. Software arms or disarms a clear alias by writing an 8-bit command code into a shifted field of the key register. While the key is armed, a write to the clear alias drops every main-control bit that is written as one. While the key is disarmed, the alias does nothing.

The bus is a simple synchronous register port. It has a byte address, a write strobe with write data, and a read strobe. Read data and the bad-access flag are registered: both appear in the cycle after the access and are zero in every other cycle. A write updates its register at the clock edge where it is sampled. The new main control word therefore shows on the control output in the next cycle.

Top module: `ccr_regs`

## Requirements
- R1: While reset is held, and right after it is released, the main word, the second word and the key are all zero. The control output, the read data and the bad-access flag are all zero.
- R2: Offset 0x30 holds the main control word and can be read and written. A write there shows on the control output in the cycle after the write.
- R3: Offset 0x34 holds the second control word and can be read and written. It has no effect on the control output.
- R4: A write to offset 0x38 whose data bits [8:1] equal 0xAE arms the key, whatever the other data bits are. A read of offset 0x38 returns the key state in bit 0 and zero in bits [31:1].
- R5: A write to offset 0x38 whose data bits [8:1] equal 0xEA disarms the key.
- R6: A write to offset 0x38 with any other value in bits [8:1] leaves the key unchanged.
- R7: While the key is armed, a write to offset 0x3C sets the main word to its old value AND NOT the write data. The result shows on the control output in the next cycle.
- R8: While the key is disarmed, a write to offset 0x3C leaves the main word unchanged.
- R9: A read of offset 0x3C is a bad access. The bad-access flag is high in the next cycle and the read data there is zero.
- R10: A read or a write at any other offset, including an unaligned one, is a bad access and changes no register.
- R11: Read data appears in the cycle after a read strobe and is zero in cycles that follow no read. When a read and a write arrive in the same cycle, the read returns the value from before the write.
- R12: The bad-access flag is high for exactly one cycle per bad access, in the cycle after it, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| bus_addr_i | input | ADDR_W (8) | Byte address of the access |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | DATA_W (32) | Write data |
| bus_re_i | input | 1 | Read strobe |
| bus_rdata_o | output | DATA_W (32) | Registered read data |
| bad_access_o | output | 1 | One-cycle flag for an access to an unmapped or write-only offset |
| main_ctrl_o | output | DATA_W (32) | Main control word to the timer channels |

## Verification
The clear alias is tried with the key disarmed, armed, re-armed after commands that are not keys, and disarmed again. This separates a clear that is correctly gated by the key from one that always applies or never applies. Arming is done with the command field surrounded by set bits, which shows whether the command is taken from the right shifted field rather than from the whole word. Reads and writes in the same cycle, reads of the write-only alias and accesses to unaligned offsets test read ordering and bad-access decoding. A long stretch of mixed random traffic, with key codes injected, is compared against the behavioural model on every clock.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

    // Which register an address selects.
    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_MAIN = 3'd1,
        SEL_AUX  = 3'd2,
        SEL_KEY  = 3'd3,
        SEL_CLR  = 3'd4
    } sel_e;

    // Result of decoding an address.
    typedef struct packed {
        logic rd_ok;
        logic wr_ok;
        sel_e sel;
    } dec_t;

endpackage

// File: rtl/ccr_decode.sv
module ccr_decode
    import ccr_pkg::*;
#(
    parameter int          ADDR_W   = 8,
    parameter logic [7:0]  MAIN_OFS = 8'h30,
    parameter logic [7:0]  AUX_OFS  = 8'h34,
    parameter logic [7:0]  KEY_OFS  = 8'h38,
    parameter logic [7:0]  CLR_OFS  = 8'h3C
) (
    input  logic [ADDR_W-1:0] addr_i,
    output dec_t              dec_o
);

    localparam logic [ADDR_W-1:0] A_MAIN = ADDR_W'(MAIN_OFS);
    localparam logic [ADDR_W-1:0] A_AUX  = ADDR_W'(AUX_OFS);
    localparam logic [ADDR_W-1:0] A_KEY  = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(CLR_OFS);

    always_comb begin
        dec_o = '{rd_ok: 1'b0, wr_ok: 1'b0, sel: SEL_NONE};
        if (addr_i == A_MAIN) begin
            dec_o = '{rd_ok: 1'b1, wr_ok: 1'b1, sel: SEL_MAIN};
        end else if (addr_i == A_AUX) begin
            dec_o = '{rd_ok: 1'b1, wr_ok: 1'b1, sel: SEL_AUX};
        end else if (addr_i == A_KEY) begin
            dec_o = '{rd_ok: 1'b1, wr_ok: 1'b1, sel: SEL_KEY};
        end else if (addr_i == A_CLR) begin
            // write-only alias
            dec_o = '{rd_ok: 1'b0, wr_ok: 1'b1, sel: SEL_CLR};
        end
    end

endmodule

// File: rtl/ccr_key.sv
module ccr_key #(
    parameter int             CMD_W       = 8,
    parameter logic [CMD_W-1:0] ARM_CODE    = 8'hAE,
    parameter logic [CMD_W-1:0] DISARM_CODE = 8'hEA
) (
    input  logic             wr_i,     // write to the key register this cycle
    input  logic [CMD_W-1:0] cmd_i,    // command field taken from the write data
    input  logic             armed_i,  // current key state
    output logic             armed_o   // next key state
);

    always_comb begin
        armed_o = armed_i;
        if (wr_i) begin
            if (cmd_i == ARM_CODE) begin
                armed_o = 1'b1;
            end else if (cmd_i == DISARM_CODE) begin
                armed_o = 1'b0;
            end
        end
    end

endmodule

// File: rtl/ccr_rdmux.sv
module ccr_rdmux
    import ccr_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  sel_e              sel_i,
    input  logic [DATA_W-1:0] main_i,
    input  logic [DATA_W-1:0] aux_i,
    input  logic              armed_i,
    output logic [DATA_W-1:0] rdata_o
);

    always_comb begin
        unique case (sel_i)
            SEL_MAIN: rdata_o = main_i;
            SEL_AUX:  rdata_o = aux_i;
            SEL_KEY:  rdata_o = {{(DATA_W-1){1'b0}}, armed_i};
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/ccr_regs.sv
module ccr_regs
    import ccr_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          DATA_W      = 32,
    parameter int          CMD_LSB     = 1,
    parameter int          CMD_W       = 8,
    parameter logic [7:0]  MAIN_OFS    = 8'h30,
    parameter logic [7:0]  AUX_OFS     = 8'h34,
    parameter logic [7:0]  KEY_OFS     = 8'h38,
    parameter logic [7:0]  CLR_OFS     = 8'h3C,
    parameter logic [7:0]  ARM_CODE    = 8'hAE,
    parameter logic [7:0]  DISARM_CODE = 8'hEA
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic              bus_we_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic              bus_re_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    output logic              bad_access_o,
    output logic [DATA_W-1:0] main_ctrl_o
);

    localparam int CMD_MSB = CMD_LSB + CMD_W - 1;

    typedef struct packed {
        logic [DATA_W-1:0] main;
        logic [DATA_W-1:0] aux;
        logic              armed;
        logic [DATA_W-1:0] rdata;
        logic              bad;
    } state_t;

    state_t state_d, state_q;

    dec_t              dec;
    logic [DATA_W-1:0] rd_val;
    logic              armed_q;
    logic              armed_nx;
    logic              key_wr;
    logic [CMD_W-1:0]  cmd;

    assign armed_q = state_q.armed;
    assign cmd     = bus_wdata_i[CMD_MSB:CMD_LSB];
    assign key_wr  = bus_we_i && dec.wr_ok && (dec.sel == SEL_KEY);

    ccr_decode #(
        .ADDR_W   (ADDR_W),
        .MAIN_OFS (MAIN_OFS),
        .AUX_OFS  (AUX_OFS),
        .KEY_OFS  (KEY_OFS),
        .CLR_OFS  (CLR_OFS)
    ) u_decode (
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    ccr_key #(
        .CMD_W       (CMD_W),
        .ARM_CODE    (CMD_W'(ARM_CODE)),
        .DISARM_CODE (CMD_W'(DISARM_CODE))
    ) u_key (
        .wr_i    (key_wr),
        .cmd_i   (cmd),
        .armed_i (armed_q),
        .armed_o (armed_nx)
    );

    ccr_rdmux #(
        .DATA_W (DATA_W)
    ) u_rdmux (
        .sel_i   (dec.sel),
        .main_i  (state_q.main),
        .aux_i   (state_q.aux),
        .armed_i (armed_q),
        .rdata_o (rd_val)
    );

    // Next-state logic
    always_comb begin
        state_d       = state_q;
        state_d.rdata = '0;
        state_d.bad   = 1'b0;
        state_d.armed = armed_nx;

        // Read side sees values from before any same-cycle write.
        if (bus_re_i) begin
            if (dec.rd_ok) begin
                state_d.rdata = rd_val;
            end else begin
                state_d.bad = 1'b1;
            end
        end

        if (bus_we_i) begin
            if (!dec.wr_ok) begin
                state_d.bad = 1'b1;
            end else begin
                unique case (dec.sel)
                    SEL_MAIN: state_d.main = bus_wdata_i;
                    SEL_AUX:  state_d.aux  = bus_wdata_i;
                    SEL_CLR: begin
                        if (state_q.armed) begin
                            state_d.main = state_q.main & ~bus_wdata_i;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // State register
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bus_rdata_o  = state_q.rdata;
    assign bad_access_o = state_q.bad;
    assign main_ctrl_o  = state_q.main;

endmodule

// File: rtl/ccr_checker.sv
module ccr_checker #(
    parameter int         ADDR_W      = 8,
    parameter int         DATA_W      = 32,
    parameter int         CMD_LSB     = 1,
    parameter int         CMD_W       = 8,
    parameter logic [7:0] KEY_OFS     = 8'h38,
    parameter logic [7:0] CLR_OFS     = 8'h3C,
    parameter logic [7:0] ARM_CODE    = 8'hAE,
    parameter logic [7:0] DISARM_CODE = 8'hEA
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic              bus_we_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              bus_re_i,
    input logic [DATA_W-1:0] bus_rdata_o,
    input logic              bad_access_o,
    input logic [DATA_W-1:0] main_ctrl_o,
    input logic              armed_q
);

    localparam logic [ADDR_W-1:0] A_KEY = ADDR_W'(KEY_OFS);
    localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(CLR_OFS);
    localparam int CMD_MSB = CMD_LSB + CMD_W - 1;

    logic key_wr, clr_wr;
    logic [CMD_W-1:0] cmd;
    assign key_wr = bus_we_i && (bus_addr_i == A_KEY);
    assign clr_wr = bus_we_i && (bus_addr_i == A_CLR);
    assign cmd    = bus_wdata_i[CMD_MSB:CMD_LSB];

    p_arm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr && cmd == CMD_W'(ARM_CODE)) |=> armed_q);

    p_key_read_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_addr_i == A_KEY) |=> (bus_rdata_o[DATA_W-1:1] == '0));

    p_disarm_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr && cmd == CMD_W'(DISARM_CODE)) |=> !armed_q);

    p_other_cmd_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (key_wr && cmd != CMD_W'(ARM_CODE) && cmd != CMD_W'(DISARM_CODE)) |=> $stable(armed_q));

    p_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && armed_q) |=> (main_ctrl_o == ($past(main_ctrl_o) & ~$past(bus_wdata_i))));

    p_locked_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && !armed_q) |=> $stable(main_ctrl_o));

    p_alias_read_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_re_i && bus_addr_i == A_CLR) |=> (bad_access_o && bus_rdata_o == '0));

    p_idle_quiet_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!bus_re_i && !bus_we_i) |=> (!bad_access_o && bus_rdata_o == '0));

endmodule

bind ccr_regs ccr_checker #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .CMD_LSB     (CMD_LSB),
    .CMD_W       (CMD_W),
    .KEY_OFS     (KEY_OFS),
    .CLR_OFS     (CLR_OFS),
    .ARM_CODE    (ARM_CODE),
    .DISARM_CODE (DISARM_CODE)
) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_addr_i   (bus_addr_i),
    .bus_we_i     (bus_we_i),
    .bus_wdata_i  (bus_wdata_i),
    .bus_re_i     (bus_re_i),
    .bus_rdata_o  (bus_rdata_o),
    .bad_access_o (bad_access_o),
    .main_ctrl_o  (main_ctrl_o),
    .armed_q      (armed_q)
);

// File: tb/ccr_regs_bench.sv
module ccr_regs_bench;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [7:0]  bus_addr_i = '0;
    logic        bus_we_i = 1'b0;
    logic [31:0] bus_wdata_i = '0;
    logic        bus_re_i = 1'b0;
    logic [31:0] bus_rdata_o;
    logic        bad_access_o;
    logic [31:0] main_ctrl_o;

    always #4 clk_i = ~clk_i;

    ccr_regs u_ccr_regs (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .bus_addr_i   (bus_addr_i),
        .bus_we_i     (bus_we_i),
        .bus_wdata_i  (bus_wdata_i),
        .bus_re_i     (bus_re_i),
        .bus_rdata_o  (bus_rdata_o),
        .bad_access_o (bad_access_o),
        .main_ctrl_o  (main_ctrl_o)
    );

    // Behavioural reference state
    int unsigned m_main, m_aux, m_arm, e_rd;
    bit          e_bad;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 1'b0;

    task automatic check(string tag, string what, int unsigned act, int unsigned exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(bit rst, bit we, bit re, logic [7:0] a, int unsigned wd);
        int unsigned cmd;
        e_rd  = 0;
        e_bad = 1'b0;
        if (rst) begin
            m_main = 0; m_aux = 0; m_arm = 0;
            return;
        end
        if (re) begin
            case (a)
                8'h30: e_rd = m_main;
                8'h34: e_rd = m_aux;
                8'h38: e_rd = m_arm;
                default: e_bad = 1'b1;
            endcase
        end
        if (we) begin
            case (a)
                8'h30: m_main = wd;
                8'h34: m_aux  = wd;
                8'h38: begin
                    cmd = (wd >> 1) & 32'hFF;
                    if (cmd == 32'hAE) m_arm = 1;
                    else if (cmd == 32'hEA) m_arm = 0;
                end
                8'h3C: if (m_arm != 0) m_main = m_main & ~wd;
                default: e_bad = 1'b1;
            endcase
        end
    endtask

    // One bus cycle: drive at falling edge, update model at rising edge,
    // compare just after it.
    task automatic step(string tag, bit we, bit re, logic [7:0] a, int unsigned wd);
        @(negedge clk_i);
        bus_we_i    = we;
        bus_re_i    = re;
        bus_addr_i  = a;
        bus_wdata_i = wd;
        @(posedge clk_i);
        model_edge(!rst_ni, we, re, a, wd);
        #1;
        check(tag, "main_ctrl_o", main_ctrl_o, m_main);
        check(tag, "bus_rdata_o", bus_rdata_o, e_rd);
        check(tag, "bad_access_o", {31'd0, bad_access_o}, {31'd0, e_bad});
    endtask

    task automatic idle(string tag);
        step(tag, 1'b0, 1'b0, 8'h00, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk_i);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned r;
        logic [7:0]  addrs [6];
        addrs = '{8'h30, 8'h34, 8'h38, 8'h3C, 8'h40, 8'h31};
        m_main = 0; m_aux = 0; m_arm = 0;

        // R1: reset state, including traffic during reset
        rst_ni = 1'b0;
        step("R1", 1'b1, 1'b0, 8'h30, 32'hFFFF_FFFF);
        step("R1", 1'b0, 1'b1, 8'h30, 0);
        @(negedge clk_i);
        rst_ni = 1'b1;
        idle("R1");
        step("R1", 1'b0, 1'b1, 8'h38, 0);

        // R2 / R3: plain read/write
        step("R2", 1'b1, 1'b0, 8'h30, 32'hFFFF_00F0);
        step("R2", 1'b0, 1'b1, 8'h30, 0);
        step("R3", 1'b1, 1'b0, 8'h34, 32'h1234_5678);
        step("R3", 1'b0, 1'b1, 8'h34, 0);

        // R8: clear alias while disarmed
        step("R8", 1'b1, 1'b0, 8'h3C, 32'h0000_00F0);
        idle("R8");

        // R6: other command keeps disarmed state
        step("R6", 1'b1, 1'b0, 8'h38, 32'h55 << 1);
        step("R6", 1'b0, 1'b1, 8'h38, 0);

        // R4: arm with command field surrounded by set bits
        step("R4", 1'b1, 1'b0, 8'h38, 32'hFFFF_FE01 | (32'hAE << 1));
        step("R4", 1'b0, 1'b1, 8'h38, 0);
        // command value placed without the shift must not arm (already armed: use after disarm below)

        // R6: other command keeps armed state
        step("R6", 1'b1, 1'b0, 8'h38, 32'h12 << 1);
        step("R6", 1'b0, 1'b1, 8'h38, 0);

        // R7: clears while armed, back to back
        step("R7", 1'b1, 1'b0, 8'h3C, 32'h0F00_0030);
        step("R7", 1'b1, 1'b0, 8'h3C, 32'h8000_0080);
        step("R7", 1'b0, 1'b1, 8'h30, 0);

        // R9: read of the write-only alias
        step("R9", 1'b0, 1'b1, 8'h3C, 0);
        idle("R12");

        // R10: unmapped and unaligned accesses
        step("R10", 1'b1, 1'b0, 8'h40, 32'hFFFF_FFFF);
        step("R10", 1'b1, 1'b0, 8'h31, 32'h0000_0000);
        step("R10", 1'b0, 1'b1, 8'h35, 0);
        step("R10", 1'b0, 1'b1, 8'h30, 0);
        step("R10", 1'b0, 1'b1, 8'h34, 0);

        // R11: read and write in the same cycle returns the old value
        step("R11", 1'b1, 1'b1, 8'h30, 32'hA5A5_5A5A);
        step("R11", 1'b0, 1'b1, 8'h30, 0);

        // R5: disarm, then alias has no effect
        step("R5", 1'b1, 1'b0, 8'h38, 32'hEA << 1);
        step("R5", 1'b0, 1'b1, 8'h38, 0);
        step("R8", 1'b1, 1'b0, 8'h3C, 32'hFFFF_FFFF);
        idle("R8");

        // R4: unshifted code must not arm
        step("R4", 1'b1, 1'b0, 8'h38, 32'hAE);
        step("R4", 1'b0, 1'b1, 8'h38, 0);

        // Mixed random traffic with injected key codes
        for (int i = 0; i < 2000; i++) begin
            r = $urandom;
            if (r[3:0] == 4'd0)
                step("R4", 1'b1, 1'b0, 8'h38, (32'hAE << 1) | (r & 32'hFFFF_FE01));
            else if (r[3:0] == 4'd1)
                step("R5", 1'b1, 1'b0, 8'h38, (32'hEA << 1) | (r & 32'hFFFF_FE01));
            else
                step("R12", r[4], r[5], addrs[r[8:6] % 6], $urandom);
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule